// File: doc/BRIEF.md
# Partial-Region Freeze Bridge Controller

This block sits between a static bus and a reconfigurable logic region. While the region is being reprogrammed, it keeps that region cut off from the bus. Software drives it through four 32-bit registers. A status word reports whether the region is frozen or running. A control word carries freeze, unfreeze and region-reset requests. A sticky error word records rejected requests. A read-only identification word returns a fixed constant.

A freeze uses a four-phase level handshake with the region. The block raises `frz_req_o` and then waits for `frz_ack_i`. The acknowledge first passes through a two-flop synchronizer. Only when the acknowledge is seen does the block report the region as frozen and close the traffic gates. An unfreeze does the reverse: it drops the request, waits for the acknowledge to fall, then reopens the gates and reports the region as running. While the region is frozen, software may hold it in reset through the control word.

A request that conflicts with the current state is rejected, and so is a request that asks for freeze and unfreeze together. A rejected request changes no state and sets a flag in the error word. The flag stays set until software writes a 1 to bit 0 of that word.

Top module: `frz_bridge_ctl`

## Requirements
- R1: Out of reset the status word (byte offset 0) reads 0x2 (bit 1 = running, bit 0 = frozen), the control word (offset 4) and error word (offset 8) read 0, `frz_req_o` and `rgn_rst_o` are low and traffic passes.
- R2: The identification word at offset 12 always reads 0xAD000003; writes to it have no effect.
- R3: A write of 0x1 to the control word while running raises `frz_req_o` from the next cycle. While the block waits for the acknowledge, the status word reads 0 and traffic still passes.
- R4: The cycle after the synchronized acknowledge is high, the status word reads 0x1. From then on every lane's `r_valid_o` and `s_ready_o` are 0.
- R5: A write of 0x4 to the control word while frozen drops `frz_req_o` from the next cycle and the status word reads 0. Traffic stays blocked until the synchronized acknowledge is low. One cycle after that, the status word reads 0x2 and traffic passes.
- R6: Status bits 0 and 1 are never both set.
- R7: A control write with the freeze bit (bit 0) set while the region is not running, or with the unfreeze bit (bit 2) set while the region is not frozen, sets error bit 0 and changes neither the state nor the control word.
- R8: A control write with both bit 0 and bit 2 set sets error bit 1, but not error bit 0, and changes nothing else.
- R9: Error bits are sticky. A write to offset 8 with bit 0 set clears the whole error word. A write there with bit 0 clear leaves it unchanged.
- R10: `rgn_rst_o` is high only when control bit 1 was written while the region was frozen and the region is still frozen. A reset bit written while the region is not frozen is stored as 0 and has no effect.
- R11: The control word reads back bits [2:0] of the last accepted control write, with bit 1 masked as in R10. Writing 0 clears all requests but does not abort a handshake in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wen | input | 1 | Register write strobe |
| csr_addr | input | 4 | Byte address of the register word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| frz_req_o | output | 1 | Freeze request to the region |
| frz_ack_i | input | 1 | Freeze acknowledge from the region (asynchronous) |
| rgn_rst_o | output | 1 | Active-high region reset |
| s_valid_i | input | LANES | Valid from the static side, one per lane |
| r_valid_o | output | LANES | Gated valid toward the region |
| r_ready_i | input | LANES | Ready from the region, one per lane |
| s_ready_o | output | LANES | Gated ready toward the static side |

## Verification
The freeze/unfreeze cycle is run with the acknowledge arriving at random delays of zero to several cycles. This separates an off-by-one in the synchronizer or state update from a correct latency. Random lane traffic runs throughout, so the bench can tell a gate that closes at the request from one that closes at the acknowledge. Every illegal pattern is tried from both stable states and from the waiting state: a freeze while frozen or freezing, an unfreeze while running, and both bits together. Each is followed by error readback and a clear. Reset requests are issued while running, while frozen and just before an unfreeze, which shows that the reset bit is masked by state and not simply stored.

// File: rtl/frz_pkg.sv
package frz_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 4;

    localparam logic [1:0] W_STATUS = 2'd0;
    localparam logic [1:0] W_CTRL   = 2'd1;
    localparam logic [1:0] W_ILL    = 2'd2;
    localparam logic [1:0] W_IDENT  = 2'd3;

    localparam logic [REG_W-1:0] IDENT_VALUE = 32'hAD00_0003;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_FREEZING = 2'd1,
        ST_FROZEN  = 2'd2,
        ST_THAWING = 2'd3
    } frz_state_e;

    // control word, bit 0 freeze, bit 1 region reset, bit 2 unfreeze
    typedef struct packed {
        logic thaw;
        logic hold_rst;
        logic frz;
    } ctrl_t;

    // error word, bit 0 conflict with state, bit 1 multiple requests
    typedef struct packed {
        logic multi;
        logic conflict;
    } ill_t;

    function automatic ill_t judge_req(ctrl_t c, frz_state_e s);
        ill_t r;
        r.multi    = c.frz & c.thaw;
        r.conflict = ~r.multi &
                     ((c.frz & (s != ST_RUN)) | (c.thaw & (s != ST_FROZEN)));
        return r;
    endfunction

endpackage

// File: rtl/frz_sync.sv
module frz_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                sh[i] <= sh[i-1];
            end
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/frz_fsm.sv
module frz_fsm
    import frz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_frz,
    input  logic       go_thaw,
    input  logic       ack_s,
    output frz_state_e state,
    output logic       frz_req,
    output logic       frz_done,
    output logic       run_done,
    output logic       pass
);
    frz_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (go_frz)  nxt = ST_FREEZING;
            ST_FREEZING: if (ack_s)   nxt = ST_FROZEN;
            ST_FROZEN:   if (go_thaw) nxt = ST_THAWING;
            ST_THAWING:  if (!ack_s)  nxt = ST_RUN;
            default:                  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    assign frz_req  = (state == ST_FREEZING) || (state == ST_FROZEN);
    assign frz_done = (state == ST_FROZEN);
    assign run_done = (state == ST_RUN);
    assign pass     = (state == ST_RUN) || (state == ST_FREEZING);

    a_r6_done_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(frz_done && run_done));

    a_r4_frozen_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(frz_done) |-> $past(ack_s));

    a_r5_run_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(run_done) |-> !$past(ack_s));
endmodule

// File: rtl/frz_gate.sv
module frz_gate #(
    parameter int unsigned LANES = 2
) (
    input  logic             pass,
    input  logic [LANES-1:0] s_valid,
    input  logic [LANES-1:0] r_ready,
    output logic [LANES-1:0] r_valid,
    output logic [LANES-1:0] s_ready
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign r_valid[i] = s_valid[i] & pass;
        assign s_ready[i] = r_ready[i] & pass;
    end
endmodule

// File: rtl/frz_csr.sv
module frz_csr
    import frz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  frz_state_e        state,
    input  logic              frz_done,
    input  logic              run_done,
    output logic [REG_W-1:0]  rdata,
    output logic              go_frz,
    output logic              go_thaw,
    output logic              rgn_rst
);
    logic [1:0] word;
    logic       wr_ctrl, wr_ill, legal;
    ctrl_t      req, ctrl_q;
    ill_t       verdict, ill_q;

    assign word    = addr[3:2];
    assign wr_ctrl = wen && (word == W_CTRL);
    assign wr_ill  = wen && (word == W_ILL);
    assign req     = ctrl_t'(wdata[2:0]);
    assign verdict = judge_req(req, state);
    assign legal   = !(verdict.multi || verdict.conflict);
    assign go_frz  = wr_ctrl && legal && req.frz;
    assign go_thaw = wr_ctrl && legal && req.thaw;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ill_q  <= '0;
        end else begin
            if (wr_ctrl && legal) begin
                ctrl_q.frz      <= req.frz;
                ctrl_q.thaw     <= req.thaw;
                ctrl_q.hold_rst <= req.hold_rst && (state == ST_FROZEN);
            end
            if (wr_ill && wdata[0]) begin
                ill_q <= '0;
            end else if (wr_ctrl) begin
                ill_q <= ill_q | verdict;
            end
        end
    end

    assign rgn_rst = ctrl_q.hold_rst && (state == ST_FROZEN);

    always_comb begin
        unique case (word)
            W_STATUS: rdata = {{(REG_W-2){1'b0}}, run_done, frz_done};
            W_CTRL:   rdata = {{(REG_W-3){1'b0}}, ctrl_q};
            W_ILL:    rdata = {{(REG_W-2){1'b0}}, ill_q};
            default:  rdata = IDENT_VALUE;
        endcase
    end

    a_r8_multi_source: assert property (@(posedge clk) disable iff (rst)
        $rose(ill_q.multi) |-> $past(wr_ctrl && wdata[0] && wdata[2]));

    a_r9_clear_word: assert property (@(posedge clk) disable iff (rst)
        (wr_ill && wdata[0]) |=> (ill_q == '0));

    a_r7_no_state_move: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !legal && (state == ST_RUN || state == ST_FROZEN))
        |=> $stable(state));
endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
    import frz_pkg::*;
#(
    parameter int unsigned LANES       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wen,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [REG_W-1:0]  csr_wdata,
    output logic [REG_W-1:0]  csr_rdata,
    output logic              frz_req_o,
    input  logic              frz_ack_i,
    output logic              rgn_rst_o,
    input  logic [LANES-1:0]  s_valid_i,
    output logic [LANES-1:0]  r_valid_o,
    input  logic [LANES-1:0]  r_ready_i,
    output logic [LANES-1:0]  s_ready_o
);
    frz_state_e state;
    logic ack_s, go_frz, go_thaw, frz_done, run_done, pass;

    frz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(frz_ack_i), .q(ack_s)
    );

    frz_csr u_csr (
        .clk(clk), .rst(rst), .wen(csr_wen), .addr(csr_addr),
        .wdata(csr_wdata), .state(state), .frz_done(frz_done),
        .run_done(run_done), .rdata(csr_rdata), .go_frz(go_frz),
        .go_thaw(go_thaw), .rgn_rst(rgn_rst_o)
    );

    frz_fsm u_fsm (
        .clk(clk), .rst(rst), .go_frz(go_frz), .go_thaw(go_thaw),
        .ack_s(ack_s), .state(state), .frz_req(frz_req_o),
        .frz_done(frz_done), .run_done(run_done), .pass(pass)
    );

    frz_gate #(.LANES(LANES)) u_gate (
        .pass(pass), .s_valid(s_valid_i), .r_ready(r_ready_i),
        .r_valid(r_valid_o), .s_ready(s_ready_o)
    );

    a_r4_gate_closed: assert property (@(posedge clk) disable iff (rst)
        frz_done |-> (r_valid_o == '0 && s_ready_o == '0));

    a_r10_rst_when_frozen: assert property (@(posedge clk) disable iff (rst)
        rgn_rst_o |-> frz_done);

    a_r3_req_from_run: assert property (@(posedge clk) disable iff (rst)
        $rose(frz_req_o) |-> $past(run_done));
endmodule

// File: tb/tb_frz_bridge_ctl.sv
`timescale 1ns/100ps
module tb_frz_bridge_ctl;
    localparam int LANES = 2;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csr_wen = 1'b0;
    logic [3:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic frz_req_o, rgn_rst_o;
    logic frz_ack_i = 1'b0;
    logic [LANES-1:0] s_valid_i = '0, r_ready_i = '0, r_valid_o, s_ready_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frz_bridge_ctl #(.LANES(LANES), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .csr_wen(csr_wen), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .frz_req_o(frz_req_o),
        .frz_ack_i(frz_ack_i), .rgn_rst_o(rgn_rst_o), .s_valid_i(s_valid_i),
        .r_valid_o(r_valid_o), .r_ready_i(r_ready_i), .s_ready_o(s_ready_o)
    );

    // reference model: 0 running, 1 freezing, 2 frozen, 3 thawing
    int m_st;
    bit [2:0] m_ctrl;
    bit [1:0] m_ill;
    bit ackq[$];

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ctrl = 0; m_ill = 0;
            ackq.delete();
            for (int i = 0; i < SYNC; i++) ackq.push_back(1'b0);
        end else begin
            int old;
            bit seen;
            old  = m_st;
            seen = ackq.pop_front();
            ackq.push_back(frz_ack_i);
            if (old == 1 && seen)  m_st = 2;
            if (old == 3 && !seen) m_st = 0;
            if (csr_wen && csr_addr[3:2] == 2'd1) begin
                bit f, r, u;
                f = csr_wdata[0]; r = csr_wdata[1]; u = csr_wdata[2];
                if (f && u) m_ill[1] = 1'b1;
                else if ((f && old != 0) || (u && old != 2)) m_ill[0] = 1'b1;
                else begin
                    m_ctrl = {u, r && (old == 2), f};
                    if (f) m_st = 1;
                    else if (u) m_st = 3;
                end
            end else if (csr_wen && csr_addr[3:2] == 2'd2 && csr_wdata[0]) begin
                m_ill = 0;
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        case (a[3:2])
            2'd0:    return {30'b0, m_st == 0, m_st == 2};
            2'd1:    return {29'b0, m_ctrl};
            2'd2:    return {30'b0, m_ill};
            default: return 32'hAD00_0003;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit pass;
            pass = (m_st == 0 || m_st == 1);
            chk("R11 rdata", csr_rdata, exp_rd(csr_addr));
            chk("R3 freeze request", {31'b0, frz_req_o}, {31'b0, (m_st == 1 || m_st == 2)});
            chk("R4 valid gate", {30'b0, r_valid_o}, {30'b0, s_valid_i & {LANES{pass}}});
            chk("R4 ready gate", {30'b0, s_ready_o}, {30'b0, r_ready_i & {LANES{pass}}});
            chk("R10 region reset", {31'b0, rgn_rst_o}, {31'b0, m_ctrl[1] && m_st == 2});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        s_valid_i = LANES'($urandom);
        r_ready_i = LANES'($urandom);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        csr_addr = a; csr_wdata = d; csr_wen = 1'b1;
        tick();
        csr_wen = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, string tag, logic [31:0] exp);
        csr_addr = a; #1;
        chk(tag, csr_rdata, exp);
    endtask

    initial begin
        ticks(3);
        rst = 1'b0;
        tick();
        rd(4'd0, "R1 status after reset", 32'h2);
        rd(4'd4, "R1 control after reset", 32'h0);
        rd(4'd8, "R1 error word after reset", 32'h0);
        chk("R1 freeze request after reset", {31'b0, frz_req_o}, 32'h0);
        rd(4'd12, "R2 identification", 32'hAD00_0003);
        wr(4'd12, 32'h0);
        rd(4'd12, "R2 identification after write", 32'hAD00_0003);

        wr(4'd4, 32'h4);
        rd(4'd8, "R7 unfreeze while running", 32'h1);
        rd(4'd0, "R7 state unchanged", 32'h2);
        wr(4'd8, 32'h0);
        rd(4'd8, "R9 write without bit0 keeps", 32'h1);
        wr(4'd8, 32'h1);
        rd(4'd8, "R9 clear", 32'h0);
        wr(4'd4, 32'h5);
        rd(4'd8, "R8 both bits", 32'h2);
        rd(4'd4, "R8 control unchanged", 32'h0);
        wr(4'd8, 32'h1);

        wr(4'd4, 32'h2);
        rd(4'd4, "R10 reset bit masked while running", 32'h0);
        chk("R10 no reset while running", {31'b0, rgn_rst_o}, 32'h0);

        wr(4'd4, 32'h3);
        rd(4'd0, "R3 status while waiting", 32'h0);
        chk("R3 request raised", {31'b0, frz_req_o}, 32'h1);
        rd(4'd4, "R11 control readback", 32'h1);
        ticks(3);
        wr(4'd4, 32'h1);
        rd(4'd8, "R7 freeze while freezing", 32'h1);
        wr(4'd8, 32'h1);
        wr(4'd4, 32'h0);
        rd(4'd0, "R11 zero write keeps handshake", 32'h0);
        frz_ack_i = 1'b1;
        ticks(4);
        rd(4'd0, "R4 frozen", 32'h1);
        chk("R4 valid blocked", {30'b0, r_valid_o}, 32'h0);
        wr(4'd4, 32'h1);
        rd(4'd8, "R7 freeze while frozen", 32'h1);
        wr(4'd8, 32'h1);
        wr(4'd4, 32'h2);
        chk("R10 reset while frozen", {31'b0, rgn_rst_o}, 32'h1);
        wr(4'd4, 32'h0);
        chk("R10 reset released", {31'b0, rgn_rst_o}, 32'h0);
        wr(4'd4, 32'h2);
        wr(4'd4, 32'h6);
        rd(4'd0, "R5 status while thawing", 32'h0);
        chk("R5 request dropped", {31'b0, frz_req_o}, 32'h0);
        chk("R10 reset drops on unfreeze", {31'b0, rgn_rst_o}, 32'h0);
        ticks(3);
        chk("R5 still blocked", {30'b0, s_ready_o}, 32'h0);
        frz_ack_i = 1'b0;
        ticks(4);
        rd(4'd0, "R5 running again", 32'h2);

        for (int k = 0; k < 10; k++) begin
            wr(4'd4, 32'h1);
            ticks($urandom_range(0, 5));
            frz_ack_i = 1'b1;
            ticks($urandom_range(4, 7));
            rd(4'd0, "R4 frozen after random delay", 32'h1);
            if (k % 2 == 0) wr(4'd4, 32'h2);
            wr(4'd4, 32'h4);
            ticks($urandom_range(0, 5));
            frz_ack_i = 1'b0;
            ticks($urandom_range(4, 7));
            rd(4'd0, "R5 running after random delay", 32'h2);
            chk("R6 flags exclusive", {31'b0, &csr_rdata[1:0]}, 32'h0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule